// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block sits between a host's memory strobes (chip enable, write enable, output enable, all active low) and an SRAM array. It decodes the strobes into an access mode and passes the matching gated controls to the array: an internal chip enable, an internal write enable and an output-drive enable. The state of the supply arrives as one digital flag, `pwr_fail`, from an external comparator.

When the supply drops below the threshold, new accesses are refused and the data outputs are released. An access that is already under way may finish, but only within a bounded number of cycles. When the supply comes back, protection stays on for a fixed recovery interval. That interval is derived from the clock rate and one of two supply settings (120 ms or 85 ms). Normal access resumes only after it has run out.

A sticky arming latch, `backup_en`, records the first time a valid supply is seen. It starts cleared, which means the backup cell stays isolated. Once set, it stays set through every later power-down.

Top module: `pfwp_ctrl`

## Requirements
- R1: In the normal state the gated outputs follow the strobes:
  - with `ce_n`=1, the outputs are `arr_ce_n`=1, `arr_we_n`=1 and `dq_oe`=0.
  - with `ce_n`=0, `we_n`=1 and `oe_n`=1, the outputs are `arr_ce_n`=0, `arr_we_n`=1 and `dq_oe`=0.
  - with `ce_n`=0, `we_n`=1 and `oe_n`=0, the outputs are `arr_ce_n`=0, `arr_we_n`=1 and `dq_oe`=1.
  - with `ce_n`=0 and `we_n`=0, the outputs are `arr_ce_n`=0, `arr_we_n`=0 and `dq_oe`=0, whatever `oe_n` is.
- R2: If a rising clock edge in the normal state samples `pwr_fail`=1 with `ce_n`=1, `protect` is 1 after that edge.
- R3: While `protect` is 1, the outputs are `arr_ce_n`=1, `arr_we_n`=1 and `dq_oe`=0, whatever the strobes are.
- R4: If a normal-state edge samples `pwr_fail`=1 with `ce_n`=0, the access goes on:
  - `protect` stays 0 and the outputs keep following the strobes.
  - the first edge that then samples `ce_n`=1 sets `protect`.
- R5: If `ce_n` stays 0 after power-fail is detected, `protect` is set on the T_WPT-th edge after the edge that detected it.
- R6: Counting the first edge that samples `pwr_fail`=0 in protection as edge 1, `protect` clears on edge T_CER+1 and not before.
- R7: T_CER equals CLK_KHZ × 120 when USE_5V=1 and CLK_KHZ × 85 when USE_5V=0.
- R8: If `pwr_fail` returns to 1 during recovery, protection is re-entered. The next recovery again takes the full T_CER.
- R9: `backup_en` is 0 after reset and stays 0 while `pwr_fail` is 1. It is 1 after the first edge that samples `pwr_fail`=0, and it stays 1 through every later power-fail.
- R10: Synchronous reset puts the block in protection: `protect`=1 with all gated outputs inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | 1 while the supply is below the power-fail threshold |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| arr_ce_n | output | 1 | Gated chip enable to the array, active low |
| arr_we_n | output | 1 | Gated write enable to the array, active low |
| dq_oe | output | 1 | Data output drive enable, 1 = drive |
| protect | output | 1 | 1 while write protection is in force |
| backup_en | output | 1 | Sticky backup-cell arming flag |

## Verification
The strobe decoder is swept over all eight strobe combinations, both in the normal state and in protection. The normal-state sweep shows that each mode is decoded apart from the others; the sweep in protection shows that nothing leaks through the gate. Power-fail is applied in three ways: with the chip idle, during a write that ends early, and during a read that never ends. These separate immediate protection, completion of the access, and the timeout. Recovery is timed on two instances with different supply settings. It is also interrupted by a repeated power-fail, which shows the recovery count restarts instead of resuming.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } pf_state_e;

    typedef enum logic [1:0] {
        MD_IDLE    = 2'd0,
        MD_NODRIVE = 2'd1,
        MD_READ    = 2'd2,
        MD_WRITE   = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic drive;
    } array_ctl_t;

    localparam array_ctl_t CTL_BLOCKED = '{ce_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic acc_mode_e decode_mode(strobe_t s);
        if (s.ce_n)      return MD_IDLE;
        else if (!s.we_n) return MD_WRITE;
        else if (!s.oe_n) return MD_READ;
        else             return MD_NODRIVE;
    endfunction

    function automatic array_ctl_t ctl_for_mode(acc_mode_e m);
        array_ctl_t c;
        case (m)
            MD_NODRIVE: c = '{ce_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            MD_READ:    c = '{ce_n: 1'b0, we_n: 1'b1, drive: 1'b1};
            MD_WRITE:   c = '{ce_n: 1'b0, we_n: 1'b0, drive: 1'b0};
            default:    c = CTL_BLOCKED;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfwp_decode.sv
module pfwp_decode
    import pfwp_pkg::*;
(
    input  strobe_t    strb,
    output array_ctl_t ctl
);
    acc_mode_e mode;

    always_comb begin
        mode = decode_mode(strb);
        ctl  = ctl_for_mode(mode);
    end
endmodule

// File: rtl/pfwp_timer.sv
module pfwp_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                     cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pfwp_fsm.sv
module pfwp_fsm
    import pfwp_pkg::*;
#(
    parameter int CW       = 8,
    parameter int WPT_LOAD = 0,
    parameter int CER_LOAD = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_fail,
    input  logic          ce_n,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_dec,
    output pf_state_e     state
);
    localparam logic [CW-1:0] WPT_V = CW'(WPT_LOAD);
    localparam logic [CW-1:0] CER_V = CW'(CER_LOAD);

    pf_state_e nxt;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        case (state)
            ST_NORMAL: if (pwr_fail) begin
                if (!ce_n) begin
                    nxt      = ST_DRAIN;
                    tmr_load = 1'b1;
                    tmr_val  = WPT_V;
                end else begin
                    nxt = ST_PROTECT;
                end
            end
            ST_DRAIN: begin
                if (ce_n || tmr_zero) nxt = ST_PROTECT;
                else                  tmr_dec = 1'b1;
            end
            ST_PROTECT: if (!pwr_fail) begin
                nxt      = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CER_V;
            end
            default: begin
                if (pwr_fail)      nxt = ST_PROTECT;
                else if (tmr_zero) nxt = ST_NORMAL;
                else               tmr_dec = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PROTECT;
        else     state <= nxt;
    end
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
    import pfwp_pkg::*;
#(
    parameter int CLK_KHZ    = 1000,
    parameter bit USE_5V     = 1'b1,
    parameter int CER_MS_5V  = 120,
    parameter int CER_MS_3V3 = 85,
    parameter int T_WPT      = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic arr_ce_n,
    output logic arr_we_n,
    output logic dq_oe,
    output logic protect,
    output logic backup_en
);
    localparam int T_CER = CLK_KHZ * (USE_5V ? CER_MS_5V : CER_MS_3V3);
    localparam int T_MAX = (T_CER > T_WPT) ? T_CER : T_WPT;
    localparam int CW    = $clog2(T_MAX + 1);

    pf_state_e     state;
    array_ctl_t    dec_ctl;
    array_ctl_t    out_ctl;
    logic          tmr_load;
    logic          tmr_dec;
    logic          tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          armed_q;

    pfwp_decode u_dec (
        .strb ('{ce_n: ce_n, we_n: we_n, oe_n: oe_n}),
        .ctl  (dec_ctl)
    );

    pfwp_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    pfwp_fsm #(
        .CW       (CW),
        .WPT_LOAD (T_WPT - 1),
        .CER_LOAD (T_CER - 1)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_fail (pwr_fail),
        .ce_n     (ce_n),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec),
        .state    (state)
    );

    always_ff @(posedge clk) begin
        if (rst)            armed_q <= 1'b0;
        else if (!pwr_fail) armed_q <= 1'b1;
    end

    always_comb begin
        protect = (state == ST_PROTECT) || (state == ST_RECOVER);
        out_ctl = protect ? CTL_BLOCKED : dec_ctl;
    end

    assign arr_ce_n  = out_ctl.ce_n;
    assign arr_we_n  = out_ctl.we_n;
    assign dq_oe     = out_ctl.drive;
    assign backup_en = armed_q;
endmodule

// File: rtl/pfwp_checker.sv
module pfwp_checker
    import pfwp_pkg::*;
#(
    parameter int T_WPT = 16
) (
    input logic      clk,
    input logic      rst,
    input logic      pwr_fail,
    input logic      ce_n,
    input pf_state_e state,
    input logic      arr_ce_n,
    input logic      arr_we_n,
    input logic      dq_oe,
    input logic      protect,
    input logic      backup_en
);
    int drain_cycles;

    always_ff @(posedge clk) begin
        if (rst)                    drain_cycles <= 0;
        else if (state == ST_DRAIN) drain_cycles <= drain_cycles + 1;
        else                        drain_cycles <= 0;
    end

    p_gate_closed_r3: assert property (@(posedge clk) disable iff (rst)
        protect |-> (arr_ce_n && arr_we_n && !dq_oe));

    p_no_drive_on_write_r1: assert property (@(posedge clk) disable iff (rst)
        !(dq_oe && !arr_we_n));

    p_idle_fail_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && pwr_fail && ce_n) |=> protect);

    p_drain_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> (drain_cycles < T_WPT));

    p_drain_ends_on_ce_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && ce_n) |=> (state == ST_PROTECT));

    p_recover_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && pwr_fail) |=> (state == ST_PROTECT));

    p_backup_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        backup_en |=> backup_en);
endmodule

bind pfwp_ctrl pfwp_checker #(.T_WPT(T_WPT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_fail  (pwr_fail),
    .ce_n      (ce_n),
    .state     (state),
    .arr_ce_n  (arr_ce_n),
    .arr_we_n  (arr_we_n),
    .dq_oe     (dq_oe),
    .protect   (protect),
    .backup_en (backup_en)
);

// File: tb/sim_pfwp_ctrl.sv
`timescale 1ns/1ps
module sim_pfwp_ctrl;
    localparam int KHZ   = 1;
    localparam int WPT   = 5;
    localparam int CER5  = KHZ * 120;
    localparam int CER33 = KHZ * 85;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic a_ce0, a_we0, oe0, prot0, bk0;
    logic a_ce1, a_we1, oe1, prot1, bk1;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pfwp_ctrl #(.CLK_KHZ(KHZ), .USE_5V(1'b1), .T_WPT(WPT)) u0 (
        .clk(clk), .rst(rst), .pwr_fail(pf), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .arr_ce_n(a_ce0), .arr_we_n(a_we0), .dq_oe(oe0), .protect(prot0), .backup_en(bk0));

    pfwp_ctrl #(.CLK_KHZ(KHZ), .USE_5V(1'b0), .T_WPT(WPT)) u1 (
        .clk(clk), .rst(rst), .pwr_fail(pf), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .arr_ce_n(a_ce1), .arr_we_n(a_we1), .dq_oe(oe1), .protect(prot1), .backup_en(bk1));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_blocked(input string req);
        chk({a_ce0, a_we0, oe0} == 3'b110, req, {a_ce0, a_we0, oe0}, 3'b110);
    endtask

    task automatic wait_normal();
        for (int i = 0; i < 400 && prot0; i++) tick();
    endtask

    task automatic measure_recovery(output int n0, output int n1);
        n0 = 0; n1 = 0;
        for (int i = 1; i <= 400; i++) begin
            tick();
            if (n0 == 0 && !prot0) n0 = i;
            if (n1 == 0 && !prot1) n1 = i;
            if (n0 != 0 && n1 != 0) break;
        end
    endtask

    initial begin
        int n0, n1, n;
        tick(); tick(); tick();
        // R10: reset state
        chk(prot0 == 1'b1, "R10 protect", prot0, 1);
        chk_blocked("R10 outputs");
        chk(bk0 == 1'b0, "R9 backup after reset", bk0, 0);
        rst = 1'b0;
        tick(); tick(); tick();
        chk(bk0 == 1'b0, "R9 backup while pf high", bk0, 0);
        // R3: sweep strobes while protected
        for (int s = 0; s < 8; s++) begin
            {ce_n, we_n, oe_n} = 3'(s);
            #1;
            chk_blocked("R3 sweep in protect");
            tick();
        end
        {ce_n, we_n, oe_n} = 3'b111;
        // R6, R7: recovery length on both supply settings
        pf = 1'b0;
        measure_recovery(n0, n1);
        chk(n0 == CER5 + 1, "R6 recovery 5V", n0, CER5 + 1);
        chk(n1 == CER33 + 1, "R7 recovery 3V3", n1, CER33 + 1);
        chk(bk0 == 1'b1, "R9 backup set", bk0, 1);
        // R1: full decode sweep in normal state
        for (int s = 0; s < 8; s++) begin
            logic c, w, o;
            logic [2:0] exp;
            {c, w, o} = 3'(s);
            {ce_n, we_n, oe_n} = {c, w, o};
            #1;
            exp = {c, c | w, ~c & w & ~o};
            chk({a_ce0, a_we0, oe0} == exp, "R1 decode", {a_ce0, a_we0, oe0}, exp);
            chk(prot0 == 1'b0, "R1 normal", prot0, 0);
            tick();
        end
        {ce_n, we_n, oe_n} = 3'b111;
        // R2: idle power-fail
        pf = 1'b1;
        tick();
        chk(prot0 == 1'b1, "R2 idle fail protects", prot0, 1);
        chk_blocked("R2 outputs");
        chk(bk0 == 1'b1, "R9 backup sticky", bk0, 1);
        pf = 1'b0;
        wait_normal();
        // R8: power-fail during recovery restarts the count
        pf = 1'b1; tick();
        pf = 1'b0;
        for (int i = 0; i < 50; i++) tick();
        chk(prot0 == 1'b1, "R8 still recovering", prot0, 1);
        pf = 1'b1; tick();
        chk(prot0 == 1'b1, "R8 back to protect", prot0, 1);
        pf = 1'b0;
        measure_recovery(n0, n1);
        chk(n0 == CER5 + 1, "R8 full recovery again", n0, CER5 + 1);
        // R4: write in flight completes when ce_n rises
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        tick();
        pf = 1'b1;
        tick(); tick(); tick();
        chk(prot0 == 1'b0, "R4 access continues", prot0, 0);
        chk({a_ce0, a_we0} == 2'b00, "R4 write passes", {a_ce0, a_we0}, 0);
        ce_n = 1'b1; we_n = 1'b1;
        #1;
        chk(a_ce0 == 1'b1, "R4 ce follows", a_ce0, 1);
        tick();
        chk(prot0 == 1'b1, "R4 protect after end", prot0, 1);
        pf = 1'b0;
        wait_normal();
        // R5: read never ends, timeout forces protection
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        tick();
        pf = 1'b1;
        n = 0;
        for (int i = 1; i <= 50; i++) begin
            tick();
            if (prot0) begin n = i; break; end
            chk(oe0 == 1'b1, "R5 read drives in drain", oe0, 1);
        end
        chk(n == WPT + 1, "R5 timeout", n, WPT + 1);
        chk_blocked("R5 outputs after timeout");
        {ce_n, we_n, oe_n} = 3'b111;
        pf = 1'b0;
        wait_normal();
        chk(bk0 == 1'b1, "R9 backup final", bk0, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule